// File: doc/BRIEF.md
# Trap Cause Priority Selector

This block picks one exception out of the fault flags that a RISC-V core with a capability extension raises for a single instruction. Fault detectors in the fetch path and in the load/store/AMO path each raise a request bit for their own class. The selector orders these bits, capability faults included, in a fixed ranking. It reports whether any fault is pending, the cause code of the winner, and a two-bit secondary code. The secondary code shows whether a normal page fault, a capability page-table fault, or both were found in the data translation step.

The access type input chooses between the load-side and the store/AMO-side code numbers. The tag-checked qualifier decides which of the two capability page-table slots a capability page-table fault request falls into. The capability cause number is a parameter, 28 by default. The output can be registered, which is the default, or passed through combinationally. The block holds no state apart from the optional output register.

Top module: `trap_cause_sel`

## Requirements
- R1: When `fetch_bkpt_i` is set, the result is cause 3 with secondary code 0, whatever other requests are set.
- R2: When the fetch breakpoint is not set, `pcc_fault_i` gives cause CAP_CAUSE (default 28).
- R3: Within the fetch path, the translation page fault (cause 12) wins over the translation access fault (cause 1). Either of them wins over the physical-address fetch access fault (cause 1).
- R4: Any fetch request outranks every data-path request, and the secondary code is then 0.
- R5: In the data path, the data breakpoint (cause 3) wins over the early misaligned fault. The early misaligned fault wins over any translation fault.
- R6: A data translation fault slot is a normal page fault, a high-slot capability page-table fault, or both. It gives the page-fault cause (13/15). The translation access fault (5/7) is reported only when neither of those is present.
- R7: Secondary code bit 0 means a normal page fault and bit 1 means a capability page-table fault. The code is non-zero only when the data translation page-fault slot wins, so the value 3 means both faults were found together.
- R8: `cap_pte_i` falls into the low slot when `tag_chk_i` is 1 and the access is not a store. Otherwise it falls into the high slot, which is the translation slot.
- R9: Below the translation slot the order is: physical data access fault (5/7), then late misaligned (4/6), then the low-slot capability page-table fault. The low-slot fault always gives cause 13.
- R10: `acc_kind_i` is encoded as 00 load, 01 store, 10 AMO and 11 reserved, and reserved is treated as AMO. A load uses causes 13/5/4 and the other encodings use 15/7/6.
- R11: With no request bit set, valid, cause and secondary code are all 0.
- R12: With REG_OUT=1 the outputs follow the inputs one clock later. While reset is asserted the outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_bkpt_i | input | 1 | Instruction address breakpoint |
| pcc_fault_i | input | 1 | Program-counter capability check fault |
| fetch_pf_i | input | 1 | Page fault during fetch translation |
| fetch_af_i | input | 1 | Access fault during fetch translation |
| fetch_paf_i | input | 1 | Access fault on the physical fetch address |
| data_bkpt_i | input | 1 | Load/store/AMO address breakpoint |
| data_mis_early_i | input | 1 | Misaligned fault taken at the early slot |
| data_pf_i | input | 1 | Normal page fault during data translation |
| cap_pte_i | input | 1 | Capability page-table fault |
| data_af_i | input | 1 | Access fault during data translation |
| data_paf_i | input | 1 | Access fault on the physical data address |
| data_mis_late_i | input | 1 | Misaligned fault taken at the late slot |
| acc_kind_i | input | 2 | Access type: 00 load, 01 store, 10 AMO, 11 reserved |
| tag_chk_i | input | 1 | The loaded tag is checked |
| trap_valid_o | output | 1 | A fault was selected |
| trap_cause_o | output | CAUSE_W | Cause code of the winning fault |
| trap_sec_o | output | 2 | Secondary code: bit 1 capability page-table fault, bit 0 normal page fault |

## Verification
With the default registered output, every result depends only on the inputs present at the rising edge before it, so each result is due exactly one clock after the stimulus. The bench changes the inputs on a falling edge. One rising edge later it samples valid, cause and secondary code on the next falling edge, and it drives the following vector in the same step. This way each vector gets exactly one register stage of latency. All 32768 combinations of request bits, access type and qualifier are swept. A separate check holds the requests high during reset to confirm that the outputs stay 0.

// File: rtl/trap_sel_pkg.sv
package trap_sel_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_AMO   = 2'b10,
        ACC_RSV   = 2'b11
    } acc_kind_t;

    localparam int C_BKPT     = 3;
    localparam int C_IPF      = 12;
    localparam int C_IAF      = 1;
    localparam int C_LD_PF    = 13;
    localparam int C_ST_PF    = 15;
    localparam int C_LD_AF    = 5;
    localparam int C_ST_AF    = 7;
    localparam int C_LD_MIS   = 4;
    localparam int C_ST_MIS   = 6;

endpackage

// File: rtl/trap_fetch_rank.sv
module trap_fetch_rank #(
    parameter int CAUSE_W   = 5,
    parameter int CAP_CAUSE = 28
) (
    input  logic               bkpt_i,
    input  logic               pcc_i,
    input  logic               pf_i,
    input  logic               af_i,
    input  logic               paf_i,
    output logic               hit_o,
    output logic [CAUSE_W-1:0] code_o
);
    import trap_sel_pkg::*;

    localparam logic [CAUSE_W-1:0] K_BKPT = CAUSE_W'(C_BKPT);
    localparam logic [CAUSE_W-1:0] K_CAP  = CAUSE_W'(CAP_CAUSE);
    localparam logic [CAUSE_W-1:0] K_IPF  = CAUSE_W'(C_IPF);
    localparam logic [CAUSE_W-1:0] K_IAF  = CAUSE_W'(C_IAF);

    always_comb begin
        hit_o  = 1'b1;
        code_o = '0;
        if (bkpt_i) begin
            code_o = K_BKPT;
        end else if (pcc_i) begin
            code_o = K_CAP;
        end else if (pf_i) begin
            code_o = K_IPF;
        end else if (af_i || paf_i) begin
            code_o = K_IAF;
        end else begin
            hit_o = 1'b0;
        end
    end

endmodule

// File: rtl/trap_data_rank.sv
module trap_data_rank #(
    parameter int CAUSE_W = 5
) (
    input  logic               bkpt_i,
    input  logic               mis_early_i,
    input  logic               pf_i,
    input  logic               cap_pte_i,
    input  logic               af_i,
    input  logic               paf_i,
    input  logic               mis_late_i,
    input  logic [1:0]         acc_i,
    input  logic               tag_chk_i,
    output logic               hit_o,
    output logic [CAUSE_W-1:0] code_o,
    output logic [1:0]         sec_o
);
    import trap_sel_pkg::*;

    logic [CAUSE_W-1:0] pf_code;
    logic [CAUSE_W-1:0] af_code;
    logic [CAUSE_W-1:0] mis_code;
    logic               is_store;
    logic               cap_hi;
    logic               cap_lo;

    always_comb begin
        is_store = 1'b0;
        unique case (acc_kind_t'(acc_i))
            ACC_LOAD: begin
                pf_code  = CAUSE_W'(C_LD_PF);
                af_code  = CAUSE_W'(C_LD_AF);
                mis_code = CAUSE_W'(C_LD_MIS);
            end
            ACC_STORE: begin
                is_store = 1'b1;
                pf_code  = CAUSE_W'(C_ST_PF);
                af_code  = CAUSE_W'(C_ST_AF);
                mis_code = CAUSE_W'(C_ST_MIS);
            end
            ACC_AMO, ACC_RSV: begin
                pf_code  = CAUSE_W'(C_ST_PF);
                af_code  = CAUSE_W'(C_ST_AF);
                mis_code = CAUSE_W'(C_ST_MIS);
            end
        endcase
    end

    assign cap_lo = cap_pte_i && tag_chk_i && !is_store;
    assign cap_hi = cap_pte_i && !cap_lo;

    always_comb begin
        hit_o  = 1'b1;
        code_o = '0;
        sec_o  = 2'b00;
        if (bkpt_i) begin
            code_o = CAUSE_W'(C_BKPT);
        end else if (mis_early_i) begin
            code_o = mis_code;
        end else if (pf_i || cap_hi) begin
            code_o = pf_code;
            sec_o  = {cap_hi, pf_i};
        end else if (af_i || paf_i) begin
            code_o = af_code;
        end else if (mis_late_i) begin
            code_o = mis_code;
        end else if (cap_lo) begin
            code_o = CAUSE_W'(C_LD_PF);
        end else begin
            hit_o = 1'b0;
        end
    end

endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage #(
    parameter int CAUSE_W = 5,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               f_hit_i,
    input  logic [CAUSE_W-1:0] f_code_i,
    input  logic               d_hit_i,
    input  logic [CAUSE_W-1:0] d_code_i,
    input  logic [1:0]         d_sec_i,
    output logic               valid_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [1:0]         sec_o
);
    logic               nxt_valid;
    logic [CAUSE_W-1:0] nxt_cause;
    logic [1:0]         nxt_sec;

    always_comb begin
        nxt_valid = f_hit_i || d_hit_i;
        nxt_cause = '0;
        nxt_sec   = 2'b00;
        if (f_hit_i) begin
            nxt_cause = f_code_i;
        end else if (d_hit_i) begin
            nxt_cause = d_code_i;
            nxt_sec   = d_sec_i;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    valid_o <= 1'b0;
                    cause_o <= '0;
                    sec_o   <= 2'b00;
                end else begin
                    valid_o <= nxt_valid;
                    cause_o <= nxt_cause;
                    sec_o   <= nxt_sec;
                end
            end
        end else begin : g_comb
            assign valid_o = nxt_valid;
            assign cause_o = nxt_cause;
            assign sec_o   = nxt_sec;
        end
    endgenerate

endmodule

// File: rtl/trap_cause_sel.sv
module trap_cause_sel #(
    parameter int CAUSE_W   = 5,
    parameter int CAP_CAUSE = 28,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               fetch_bkpt_i,
    input  logic               pcc_fault_i,
    input  logic               fetch_pf_i,
    input  logic               fetch_af_i,
    input  logic               fetch_paf_i,
    input  logic               data_bkpt_i,
    input  logic               data_mis_early_i,
    input  logic               data_pf_i,
    input  logic               cap_pte_i,
    input  logic               data_af_i,
    input  logic               data_paf_i,
    input  logic               data_mis_late_i,
    input  logic [1:0]         acc_kind_i,
    input  logic               tag_chk_i,
    output logic               trap_valid_o,
    output logic [CAUSE_W-1:0] trap_cause_o,
    output logic [1:0]         trap_sec_o
);
    logic               f_hit;
    logic [CAUSE_W-1:0] f_code;
    logic               d_hit;
    logic [CAUSE_W-1:0] d_code;
    logic [1:0]         d_sec;

    trap_fetch_rank #(
        .CAUSE_W  (CAUSE_W),
        .CAP_CAUSE(CAP_CAUSE)
    ) u_fetch (
        .bkpt_i(fetch_bkpt_i),
        .pcc_i (pcc_fault_i),
        .pf_i  (fetch_pf_i),
        .af_i  (fetch_af_i),
        .paf_i (fetch_paf_i),
        .hit_o (f_hit),
        .code_o(f_code)
    );

    trap_data_rank #(
        .CAUSE_W(CAUSE_W)
    ) u_data (
        .bkpt_i     (data_bkpt_i),
        .mis_early_i(data_mis_early_i),
        .pf_i       (data_pf_i),
        .cap_pte_i  (cap_pte_i),
        .af_i       (data_af_i),
        .paf_i      (data_paf_i),
        .mis_late_i (data_mis_late_i),
        .acc_i      (acc_kind_i),
        .tag_chk_i  (tag_chk_i),
        .hit_o      (d_hit),
        .code_o     (d_code),
        .sec_o      (d_sec)
    );

    trap_out_stage #(
        .CAUSE_W(CAUSE_W),
        .REG_OUT(REG_OUT)
    ) u_out (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .f_hit_i (f_hit),
        .f_code_i(f_code),
        .d_hit_i (d_hit),
        .d_code_i(d_code),
        .d_sec_i (d_sec),
        .valid_o (trap_valid_o),
        .cause_o (trap_cause_o),
        .sec_o   (trap_sec_o)
    );

endmodule

// File: rtl/trap_cause_sel_chk.sv
module trap_cause_sel_chk #(
    parameter int CAUSE_W   = 5,
    parameter int CAP_CAUSE = 28,
    parameter bit REG_OUT   = 1'b1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [11:0]        req_i,
    input logic               trap_valid_o,
    input logic [CAUSE_W-1:0] trap_cause_o,
    input logic [1:0]         trap_sec_o
);
    logic [11:0] seen;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) seen <= '0;
                else         seen <= req_i;
            end
        end else begin : g_now
            assign seen = req_i;
        end
    endgenerate

    // R1
    p_fetch_bkpt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen[0] |-> (trap_valid_o && trap_cause_o == CAUSE_W'(3) && trap_sec_o == 2'b00));

    // R2
    p_pcc_rank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen[1] && !seen[0]) |-> (trap_cause_o == CAUSE_W'(CAP_CAUSE)));

    // R4
    p_fetch_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|seen[4:0]) |-> (trap_sec_o == 2'b00 &&
            (trap_cause_o == CAUSE_W'(3) || trap_cause_o == CAUSE_W'(CAP_CAUSE) ||
             trap_cause_o == CAUSE_W'(12) || trap_cause_o == CAUSE_W'(1))));

    // R7
    p_sec_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_sec_o != 2'b00) |-> (trap_cause_o == CAUSE_W'(13) || trap_cause_o == CAUSE_W'(15)));

    // R11
    p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen == '0) |-> (!trap_valid_o && trap_cause_o == '0 && trap_sec_o == 2'b00));

    // R11
    p_any_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen != '0) |-> trap_valid_o);

endmodule

bind trap_cause_sel trap_cause_sel_chk #(
    .CAUSE_W  (CAUSE_W),
    .CAP_CAUSE(CAP_CAUSE),
    .REG_OUT  (REG_OUT)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       ({data_mis_late_i, data_paf_i, data_af_i, cap_pte_i, data_pf_i,
                   data_mis_early_i, data_bkpt_i, fetch_paf_i, fetch_af_i,
                   fetch_pf_i, pcc_fault_i, fetch_bkpt_i}),
    .trap_valid_o(trap_valid_o),
    .trap_cause_o(trap_cause_o),
    .trap_sec_o  (trap_sec_o)
);

// File: tb/trap_cause_sel_tb_top.sv
module trap_cause_sel_tb_top;

    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   req = '0;
    logic [1:0]    acc = 2'b00;
    logic          tchk = 1'b0;
    logic          valid;
    logic [CW-1:0] cause;
    logic [1:0]    sec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trap_cause_sel dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .fetch_bkpt_i    (req[0]),
        .pcc_fault_i     (req[1]),
        .fetch_pf_i      (req[2]),
        .fetch_af_i      (req[3]),
        .fetch_paf_i     (req[4]),
        .data_bkpt_i     (req[5]),
        .data_mis_early_i(req[6]),
        .data_pf_i       (req[7]),
        .cap_pte_i       (req[8]),
        .data_af_i       (req[9]),
        .data_paf_i      (req[10]),
        .data_mis_late_i (req[11]),
        .acc_kind_i      (acc),
        .tag_chk_i       (tchk),
        .trap_valid_o    (valid),
        .trap_cause_o    (cause),
        .trap_sec_o      (sec)
    );

    task automatic expect_of(input logic [14:0] v, output logic [7:0] e, output string tag);
        logic ld, st, lo, hi;
        int pfc, afc, mc;
        ld  = (v[13:12] == 2'b00);
        st  = (v[13:12] == 2'b01);
        pfc = ld ? 13 : 15;
        afc = ld ? 5 : 7;
        mc  = ld ? 4 : 6;
        lo  = v[8] && v[14] && !st;
        hi  = v[8] && !lo;
        if (v[0])             begin e = {1'b1, 5'd3, 2'b00};  tag = "R1"; end
        else if (v[1])        begin e = {1'b1, 5'd28, 2'b00}; tag = "R2"; end
        else if (v[2])        begin e = {1'b1, 5'd12, 2'b00}; tag = "R3"; end
        else if (v[3] | v[4]) begin e = {1'b1, 5'd1, 2'b00};  tag = "R3"; end
        else if (v[5])        begin e = {1'b1, 5'd3, 2'b00};  tag = "R5"; end
        else if (v[6])        begin e = {1'b1, 5'(mc), 2'b00}; tag = "R5"; end
        else if (v[7] | hi)   begin e = {1'b1, 5'(pfc), hi, v[7]}; tag = "R7"; end
        else if (v[9] | v[10]) begin e = {1'b1, 5'(afc), 2'b00}; tag = "R6"; end
        else if (v[11])       begin e = {1'b1, 5'(mc), 2'b00}; tag = "R9"; end
        else if (lo)          begin e = {1'b1, 5'd13, 2'b00}; tag = "R8"; end
        else                  begin e = 8'h00; tag = "R11"; end
    endtask

    task automatic check(input string tag, input logic [7:0] exp_v);
        logic [7:0] act;
        act = {valid, cause, sec};
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual valid=%0b cause=%0d sec=%0d expected valid=%0b cause=%0d sec=%0d",
                     tag, act[7], act[6:2], act[1:0], exp_v[7], exp_v[6:2], exp_v[1:0]);
        end
    endtask

    task automatic drive(input logic [14:0] v);
        req  = v[11:0];
        acc  = v[13:12];
        tchk = v[14];
    endtask

    initial begin
        logic [7:0] e;
        string      tag;
        logic [14:0] prev;
        repeat (3) @(negedge clk);
        check("R12 reset idle", 8'h00);
        drive(15'h0FFF);
        repeat (2) @(negedge clk);
        check("R12 held in reset", 8'h00);
        rst_n = 1'b1;
        drive(15'h0000);
        prev = 15'h0000;
        for (int v = 0; v < 32768; v++) begin
            @(negedge clk);
            expect_of(prev, e, tag);
            check(tag, e);
            drive(15'(v));
            prev = 15'(v);
        end
        @(negedge clk);
        expect_of(prev, e, tag);
        check(tag, e);
        // R10: store-side codes for a late misaligned fault, reserved access type as AMO
        drive({1'b0, 2'b11, 12'h800});
        @(negedge clk);
        check("R10 reserved acc", {1'b1, 5'd6, 2'b00});
        // R7: both page faults found together, on a load
        drive({1'b0, 2'b00, 12'h180});
        @(negedge clk);
        check("R7 both faults", {1'b1, 5'd13, 2'b11});
        // R12: outputs clear when reset asserts again
        rst_n = 1'b0;
        #1;
        check("R12 async clear", 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule